// File: doc/BRIEF.md
# Hot-Swap Fault Sequencer

This block is the digital control core of a power-switch controller for boards that are plugged into a live backplane. It takes comparator flags that are already synchronous and digital: overcurrent, overvoltage, undervoltage, power-good, card-present, the ON request, start-up-complete and timer-expired. From these it decides when the external pass switch may be driven, when the external timer is armed, and which faults are recorded for the host.

The sequencer moves through idle, start-up, on, cool-down and latched-off states. After an overcurrent it either stays latched off or waits out a cool-down and tries again, depending on a host setting. Faults are held in a sticky register that the host clears by writing ones. A newly recorded fault raises an alert request. A separate output pin can show power-good, show its inverse, act as a host-driven output, or be released as an input. The host reaches the settings and the fault register through a small parallel register port.

Top module: `hsw_sequencer`

## Requirements
- R1: After reset the gate enable, timer start, alert and power-good pin outputs are low. The fault register reads 0 and the control register reads 0. The cool-down count register (address 2) reads its reset value, which is 2 by default.
- R2: When idle with card present, ON requested, and no undervoltage or overvoltage, the gate enable rises one cycle later. The timer start output pulses high for exactly that first start-up cycle.
- R3: An overcurrent flag seen while the gate is enabled sets fault bit 2 and drops the gate enable one cycle later.
- R4: With control bit 0 clear (latch-off), the gate stays off after an overcurrent until the card-present flag falls. That fall sets fault bit 4. A later rise of card-present restarts start-up.
- R5: With control bit 0 set (auto-retry), an overcurrent enters cool-down and pulses timer start. Cool-down counts timer-expired pulses and ends only once the count has reached the value at address 2 and the overcurrent flag is clear. The block then goes idle and restarts on the next cycle.
- R6: An overvoltage flag sets fault bit 0 and forces the gate enable low one cycle later. The gate stays low while the flag is held.
- R7: A low power-good flag sets fault bit 3 only while the block is in the on state, which is reached when start-up-complete is seen during start-up. During start-up a low power-good flag logs nothing.
- R8: While undervoltage is high or the ON request is low, the gate stays off and no fault is logged. Start-up resumes one cycle after both conditions clear.
- R9: Writing to address 1 clears each fault bit whose write-data bit is 1 and leaves the other bits unchanged. A set event in the same cycle wins over the clear.
- R10: The alert output rises in the cycle after any fault bit goes from 0 to 1. It stays high until the whole fault register reads 0.
- R11: Control bits 7:6 select the power-good pin. 00 gives power-good while in the on state, 01 gives the inverse of that, 10 drives control bit 1 onto the pin, and 11 releases the pin to low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| oc_i | input | 1 | Overcurrent flag |
| ov_i | input | 1 | Overvoltage flag |
| uv_i | input | 1 | Undervoltage flag |
| pg_i | input | 1 | Power-good comparator flag |
| card_i | input | 1 | Card-present flag |
| on_i | input | 1 | ON request |
| su_done_i | input | 1 | Start-up complete flag |
| tmr_exp_i | input | 1 | Timer-expired pulse |
| host_we_i | input | 1 | Host write strobe |
| host_addr_i | input | 2 | Host register address (0 control, 1 faults, 2 cool-down count) |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data for the addressed register |
| gate_en_o | output | 1 | Enable for the external gate driver |
| tmr_start_o | output | 1 | One-cycle pulse that arms the external timer |
| fault_o | output | 8 | Sticky fault register |
| pg_out_o | output | 1 | Power-good pin output |
| alert_o | output | 1 | Alert request to the host |

## Verification
Every result is held in a register that loads on the edge where the stimulus is sampled, so each result is due one cycle after the stimulus. This covers the state and gate enable, the timer pulse, the fault bits, the alert and register writes. Read data and the power-good pin follow those registers through logic only, so they are due in the same cycle. A restart after cool-down takes two more edges: one to go idle, one to start. The driver queues each expected item while the inputs are being applied half a cycle before the edge, and the monitor compares it just after that edge, so every comparison lands on the cycle where the result is due.

// File: rtl/hsw_pkg.sv
// Shared types for the hot-swap fault sequencer.
// Assumes fault bit positions are fixed by the host-visible register layout.
package hsw_pkg;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_START = 3'd1,
        ST_ON    = 3'd2,
        ST_COOL  = 3'd3,
        ST_LATCH = 3'd4
    } seq_state_t;

    typedef enum logic [1:0] {
        PGM_GOOD = 2'b00,
        PGM_INV  = 2'b01,
        PGM_GPO  = 2'b10,
        PGM_GPI  = 2'b11
    } pg_mode_t;

    localparam int FB_OV = 0;
    localparam int FB_OC = 2;
    localparam int FB_PB = 3;
    localparam int FB_RM = 4;
endpackage

// File: rtl/hsw_host_regs.sv
// Host register file: control (addr 0), fault clear/readback (addr 1),
// cool-down pulse count (addr 2). Assumes single-cycle write strobes.
module hsw_host_regs
    import hsw_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int COOL_RST = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [1:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] fault_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [DATA_W-1:0] clr_o,
    output logic              retry_o,
    output logic              gpo_o,
    output pg_mode_t          pg_mode_o,
    output logic [CNT_W-1:0]  cool_o
);
    logic [DATA_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  cool_q;

    // Store control and cool-down registers on host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cool_q <= CNT_W'(COOL_RST);
        end else if (we_i) begin
            if (addr_i == 2'd0) ctrl_q <= wdata_i;
            if (addr_i == 2'd2) cool_q <= CNT_W'(wdata_i);
        end
    end

    // Decode write-one-to-clear mask for the fault register.
    always_comb begin
        clr_o = (we_i && addr_i == 2'd1) ? wdata_i : '0;
    end

    // Select read data for the addressed register.
    always_comb begin
        case (addr_i)
            2'd0:    rdata_o = ctrl_q;
            2'd1:    rdata_o = fault_i;
            2'd2:    rdata_o = DATA_W'(cool_q);
            default: rdata_o = '0;
        endcase
    end

    assign retry_o   = ctrl_q[0];
    assign gpo_o     = ctrl_q[1];
    assign pg_mode_o = pg_mode_t'(ctrl_q[DATA_W-1 -: 2]);
    assign cool_o    = cool_q;
endmodule

// File: rtl/hsw_seq_fsm.sv
// Sequencing state machine: idle, start-up, on, cool-down, latched-off.
// Produces gate enable, timer start pulse and fault set events.
// Assumes all flags are synchronous to clk.
module hsw_seq_fsm
    import hsw_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              oc_i,
    input  logic              ov_i,
    input  logic              uv_i,
    input  logic              pg_i,
    input  logic              card_i,
    input  logic              on_i,
    input  logic              su_done_i,
    input  logic              tmr_exp_i,
    input  logic              retry_i,
    input  logic [CNT_W-1:0]  cool_i,
    output logic              gate_en_o,
    output logic              tmr_start_o,
    output logic              pwr_on_o,
    output logic [DATA_W-1:0] set_o
);
    seq_state_t       st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic             card_q;
    logic             tst_q;
    logic             blocked;

    assign blocked = ov_i || uv_i || !on_i || !card_i;

    // Next-state decision.
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_OFF:   if (!blocked) st_d = ST_START;
            ST_START, ST_ON: begin
                if (blocked)               st_d = ST_OFF;
                else if (oc_i)             st_d = retry_i ? ST_COOL : ST_LATCH;
                else if (st_q == ST_START && su_done_i) st_d = ST_ON;
            end
            ST_COOL:  if (cnt_q >= cool_i && !oc_i) st_d = ST_OFF;
            ST_LATCH: if (!card_i) st_d = ST_OFF;
            default:  st_d = ST_OFF;
        endcase
    end

    // State, cool-down counter, card history and timer pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_OFF;
            cnt_q  <= '0;
            card_q <= 1'b0;
            tst_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            card_q <= card_i;
            tst_q  <= (st_d == ST_START && st_q != ST_START) ||
                      (st_d == ST_COOL  && st_q != ST_COOL);
            if (st_q != ST_COOL)
                cnt_q <= '0;
            else if (tmr_exp_i && cnt_q != '1)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign gate_en_o   = (st_q == ST_START) || (st_q == ST_ON);
    assign pwr_on_o    = (st_q == ST_ON);
    assign tmr_start_o = tst_q;

    // Fault events raised this cycle.
    always_comb begin
        set_o        = '0;
        set_o[FB_OV] = ov_i;
        set_o[FB_OC] = oc_i && gate_en_o;
        set_o[FB_PB] = (st_q == ST_ON) && !pg_i;
        set_o[FB_RM] = card_q && !card_i;
    end

    a_r3_oc_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en_o && oc_i) |=> !gate_en_o);
    a_r6_ov_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
        ov_i |=> !gate_en_o);
    a_r8_block_off: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_i || !on_i) |=> !gate_en_o);
    a_r2_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_en_o) |-> tmr_start_o);
    a_r5_cool_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_COOL && cnt_q < cool_i) |=> st_q == ST_COOL);
    a_r4_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LATCH && card_i) |=> st_q == ST_LATCH);
endmodule

// File: rtl/hsw_fault_log.sv
// Sticky fault register with write-one-to-clear and alert request.
// Assumes set events win over a clear in the same cycle.
module hsw_fault_log
    import hsw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_i,
    input  logic [DATA_W-1:0] clr_i,
    output logic [DATA_W-1:0] fault_o,
    output logic              alert_o
);
    logic [DATA_W-1:0] fault_q, fault_d;
    logic              alert_q;
    logic              fresh;

    // Combine clears and new events into the next register value.
    always_comb begin
        fault_d = (fault_q & ~clr_i) | set_i;
        fresh   = |(set_i & ~fault_q);
    end

    // Hold faults and the alert until the register empties.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= '0;
            alert_q <= 1'b0;
        end else begin
            fault_q <= fault_d;
            alert_q <= (alert_q || fresh) && (fault_d != '0);
        end
    end

    assign fault_o = fault_q;
    assign alert_o = alert_q;

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i == '0) |=> ((fault_q & $past(fault_q)) == $past(fault_q)));
    a_r10_alert_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q == '0) |-> !alert_q);
    a_r10_alert_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i & ~fault_q) != '0) |=> alert_q);
endmodule

// File: rtl/hsw_pg_out.sv
// Power-good pin selector: indication, inverse, host output or released.
// Assumes the released (input) mode is modelled as a low output.
module hsw_pg_out
    import hsw_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pg_mode_t mode_i,
    input  logic     pg_i,
    input  logic     pwr_on_i,
    input  logic     gpo_i,
    output logic     pg_out_o
);
    logic good;

    // Pick the pin value for the selected mode.
    always_comb begin
        good = pg_i && pwr_on_i;
        case (mode_i)
            PGM_GOOD: pg_out_o = good;
            PGM_INV:  pg_out_o = !good;
            PGM_GPO:  pg_out_o = gpo_i;
            default:  pg_out_o = 1'b0;
        endcase
    end

    a_r11_gpi_released: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == PGM_GPI) |-> !pg_out_o);
    a_r11_good_needs_on: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == PGM_GOOD && pg_out_o) |-> pwr_on_i);
endmodule

// File: rtl/hsw_sequencer.sv
// Top of the hot-swap fault sequencer: wires the host registers, the
// sequencing state machine, the fault log and the power-good pin selector.
// Assumes all inputs are synchronous to clk.
module hsw_sequencer
    import hsw_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int COOL_RST = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              oc_i,
    input  logic              ov_i,
    input  logic              uv_i,
    input  logic              pg_i,
    input  logic              card_i,
    input  logic              on_i,
    input  logic              su_done_i,
    input  logic              tmr_exp_i,
    input  logic              host_we_i,
    input  logic [1:0]        host_addr_i,
    input  logic [DATA_W-1:0] host_wdata_i,
    output logic [DATA_W-1:0] host_rdata_o,
    output logic              gate_en_o,
    output logic              tmr_start_o,
    output logic [DATA_W-1:0] fault_o,
    output logic              pg_out_o,
    output logic              alert_o
);
    logic [DATA_W-1:0] clr, set;
    logic              retry, gpo, pwr_on;
    pg_mode_t          pg_mode;
    logic [CNT_W-1:0]  cool;

    hsw_host_regs #(.CNT_W(CNT_W), .COOL_RST(COOL_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(host_we_i), .addr_i(host_addr_i),
        .wdata_i(host_wdata_i), .fault_i(fault_o), .rdata_o(host_rdata_o),
        .clr_o(clr), .retry_o(retry), .gpo_o(gpo), .pg_mode_o(pg_mode),
        .cool_o(cool)
    );

    hsw_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .oc_i(oc_i), .ov_i(ov_i), .uv_i(uv_i),
        .pg_i(pg_i), .card_i(card_i), .on_i(on_i), .su_done_i(su_done_i),
        .tmr_exp_i(tmr_exp_i), .retry_i(retry), .cool_i(cool),
        .gate_en_o(gate_en_o), .tmr_start_o(tmr_start_o),
        .pwr_on_o(pwr_on), .set_o(set)
    );

    hsw_fault_log u_log (
        .clk(clk), .rst_n(rst_n), .set_i(set), .clr_i(clr),
        .fault_o(fault_o), .alert_o(alert_o)
    );

    hsw_pg_out u_pg (
        .clk(clk), .rst_n(rst_n), .mode_i(pg_mode), .pg_i(pg_i),
        .pwr_on_i(pwr_on), .gpo_i(gpo), .pg_out_o(pg_out_o)
    );
endmodule

// File: tb/hsw_sequencer_bench.sv
// Scoreboard bench: the driver queues the expected outputs for each checked
// cycle, and the monitor pops and compares them just after the clock edge.
module hsw_sequencer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       oc = 0, ov = 0, uv = 0, pg = 0, card = 0, on = 0, su = 0, tex = 0;
    logic       we = 0;
    logic [1:0] addr = 0;
    logic [7:0] wd = 0;
    logic [7:0] rd, fault;
    logic       gate, tst, pgo, alert;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct packed {
        logic       g;
        logic       t;
        logic [7:0] f;
        logic       a;
        logic       p;
        logic       rc;
        logic [7:0] r;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    hsw_sequencer u_hsw_sequencer (
        .clk(clk), .rst_n(rst_n), .oc_i(oc), .ov_i(ov), .uv_i(uv), .pg_i(pg),
        .card_i(card), .on_i(on), .su_done_i(su), .tmr_exp_i(tex),
        .host_we_i(we), .host_addr_i(addr), .host_wdata_i(wd),
        .host_rdata_o(rd), .gate_en_o(gate), .tmr_start_o(tst),
        .fault_o(fault), .pg_out_o(pgo), .alert_o(alert)
    );

    // Driver: queue the expectation for the coming edge, then advance.
    task automatic cyc(input bit chk, input logic g, input logic t,
                       input logic [7:0] f, input logic a, input logic p,
                       input logic rc, input logic [7:0] r, input string tag);
        exp_t e;
        if (chk) begin
            e = '{g: g, t: t, f: f, a: a, p: p, rc: rc, r: r};
            exp_q.push_back(e);
            tag_q.push_back(tag);
        end
        @(negedge clk);
    endtask

    // Monitor: compare outputs 2 ns after each rising edge.
    always @(posedge clk) begin
        exp_t  e;
        string tg;
        #2;
        if (exp_q.size() != 0) begin
            e  = exp_q.pop_front();
            tg = tag_q.pop_front();
            checks++;
            if (gate !== e.g || tst !== e.t || fault !== e.f || alert !== e.a ||
                pgo !== e.p || (e.rc && rd !== e.r)) begin
                errors++;
                $display("FAIL %s: got gate=%b tst=%b fault=%h alert=%b pg=%b rd=%h, expected gate=%b tst=%b fault=%h alert=%b pg=%b rd=%h",
                         tg, gate, tst, fault, alert, pgo, rd,
                         e.g, e.t, e.f, e.a, e.p, e.r);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #100000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got no end, expected end of stimulus");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) cyc(0, 0, 0, 8'h00, 0, 0, 0, 8'h00, "");
        rst_n = 1; addr = 2;
        cyc(1, 0, 0, 8'h00, 0, 0, 1, 8'h02, "R1 reset state");
        addr = 0; card = 1; on = 1; uv = 1;
        cyc(1, 0, 0, 8'h00, 0, 0, 1, 8'h00, "R8 undervoltage holds off");
        cyc(1, 0, 0, 8'h00, 0, 0, 0, 8'h00, "R8 undervoltage holds off again");
        uv = 0;
        cyc(1, 1, 1, 8'h00, 0, 0, 0, 8'h00, "R2 start-up with timer pulse");
        cyc(1, 1, 0, 8'h00, 0, 0, 0, 8'h00, "R2 single timer pulse, R7 no power-bad in start-up");
        su = 1; pg = 1;
        cyc(1, 1, 0, 8'h00, 0, 1, 0, 8'h00, "R7 on state reached");
        su = 0; pg = 0;
        cyc(1, 1, 0, 8'h08, 1, 0, 0, 8'h00, "R7 power-bad logged, R10 alert");
        pg = 1; we = 1; addr = 1; wd = 8'h08;
        cyc(1, 1, 0, 8'h00, 0, 1, 0, 8'h00, "R9 clear power-bad");
        we = 0; addr = 0; oc = 1;
        cyc(1, 0, 0, 8'h04, 1, 0, 0, 8'h00, "R3 overcurrent turns gate off");
        oc = 0;
        cyc(1, 0, 0, 8'h04, 1, 0, 0, 8'h00, "R4 latched off");
        cyc(1, 0, 0, 8'h04, 1, 0, 0, 8'h00, "R4 still latched off");
        card = 0;
        cyc(1, 0, 0, 8'h14, 1, 0, 0, 8'h00, "R4 card removal logged");
        card = 1;
        cyc(1, 1, 1, 8'h14, 1, 0, 0, 8'h00, "R4 reinsertion restarts");
        we = 1; addr = 1; wd = 8'hFF;
        cyc(1, 1, 0, 8'h00, 0, 0, 0, 8'h00, "R9 clear all faults");
        addr = 0; wd = 8'h01;
        cyc(1, 1, 0, 8'h00, 0, 0, 1, 8'h01, "R5 auto-retry enabled");
        addr = 2; wd = 8'h02;
        cyc(1, 1, 0, 8'h00, 0, 0, 1, 8'h02, "R5 cool-down count written");
        we = 0; addr = 0; oc = 1;
        cyc(1, 0, 1, 8'h04, 1, 0, 0, 8'h00, "R5 cool-down entry");
        tex = 1;
        cyc(1, 0, 0, 8'h04, 1, 0, 0, 8'h00, "R5 first pulse with overcurrent");
        cyc(1, 0, 0, 8'h04, 1, 0, 0, 8'h00, "R5 second pulse with overcurrent");
        tex = 0; oc = 0;
        cyc(1, 0, 0, 8'h04, 1, 0, 0, 8'h00, "R5 idle after cool-down");
        cyc(1, 1, 1, 8'h04, 1, 0, 0, 8'h00, "R5 retry start-up");
        oc = 1;
        cyc(1, 0, 1, 8'h04, 1, 0, 0, 8'h00, "R5 second cool-down");
        oc = 0; tex = 1;
        cyc(1, 0, 0, 8'h04, 1, 0, 0, 8'h00, "R5 one pulse counted");
        tex = 0;
        cyc(1, 0, 0, 8'h04, 1, 0, 0, 8'h00, "R5 one pulse short of count");
        tex = 1;
        cyc(1, 0, 0, 8'h04, 1, 0, 0, 8'h00, "R5 count reached");
        tex = 0;
        cyc(1, 0, 0, 8'h04, 1, 0, 0, 8'h00, "R5 idle after count");
        cyc(1, 1, 1, 8'h04, 1, 0, 0, 8'h00, "R5 restart after count");
        ov = 1;
        cyc(1, 0, 0, 8'h05, 1, 0, 0, 8'h00, "R6 overvoltage turns gate off");
        cyc(1, 0, 0, 8'h05, 1, 0, 0, 8'h00, "R6 held off during overvoltage");
        ov = 0;
        cyc(1, 1, 1, 8'h05, 1, 0, 0, 8'h00, "R6 restart after overvoltage");
        we = 1; addr = 0; wd = 8'h83;
        cyc(1, 1, 0, 8'h05, 1, 1, 1, 8'h83, "R11 host output mode");
        wd = 8'h41;
        cyc(1, 1, 0, 8'h05, 1, 1, 1, 8'h41, "R11 inverted mode");
        wd = 8'hC1;
        cyc(1, 1, 0, 8'h05, 1, 0, 1, 8'hC1, "R11 released mode");
        we = 0; on = 0;
        cyc(1, 0, 0, 8'h05, 1, 0, 0, 8'h00, "R8 ON request low turns off");
        on = 1;
        cyc(1, 1, 1, 8'h05, 1, 0, 0, 8'h00, "R8 resume on request");
        we = 1; addr = 1; wd = 8'h01;
        cyc(1, 1, 0, 8'h04, 1, 0, 0, 8'h00, "R10 alert held with faults left");
        wd = 8'h04;
        cyc(1, 1, 0, 8'h00, 0, 0, 0, 8'h00, "R10 alert cleared when empty");
        we = 0;
        repeat (2) cyc(0, 0, 0, 8'h00, 0, 0, 0, 8'h00, "");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule